// File: doc/BRIEF.md
# Write-Protect Status Guard

This block holds the status byte of a serial nonvolatile memory and decides, for each write request, whether the write may go ahead. Command strobes come from the serial front end: set the write-enable latch, clear it, and write the status byte with a data byte. The block also takes an active-low hardware protect pin, a busy flag and a write-complete pulse from the write-cycle timer, a flag that is high while a status-write data byte is still being shifted in, and the target address of each array write request.

The block returns the status byte for readback and two one-cycle permit pulses. One permit is for status writes and one is for array writes. A refused request leaves every register as it was and raises no error. The protect bits are ordinary resettable registers.

Top module: `wp_status_guard`

## Requirements
- R1: After reset, with busy low, the status byte reads 0x00. The sticky pin-enable bit, both block-protect bits and the enable latch are all cleared.
- R2: With busy low, the status byte is {sticky pin-enable (bit 7), 0, 0, 0, protect level bit 1 (bit 3), protect level bit 0 (bit 2), enable latch (bit 1), 0 (bit 0)}.
- R3: While busy is high, the status byte reads 0xFF.
- R4: A set-latch strobe sets the enable latch from the next cycle. A clear-latch strobe clears it from the next cycle whatever the pin level. Clear wins when both strobes arrive together.
- R5: The write-complete pulse clears the enable latch in the next cycle.
- R6: An accepted status write copies data bits 7, 3 and 2 into the status byte and ignores the other data bits. It needs the enable latch, and it raises the status permit for one cycle in the next cycle.
- R7: When the pin is low and the sticky pin-enable bit is 1, a status write is refused. When the sticky pin-enable bit is 0, the pin has no effect.
- R8: The protect level is 00 for none, 01 for the top quarter (top two address bits = 11), 10 for the top half (top address bit = 1) and 11 for all addresses. An array write inside the protected region is refused.
- R9: An array write outside the protected region needs the enable latch, and it raises the array permit for one cycle in the next cycle.
- R10: If the lock condition (pin low with the sticky bit set) holds in any cycle while a status byte is being shifted in, the next status write is refused even if the pin has gone high again.
- R11: While busy is high, the set-latch, clear-latch, status-write and array-write strobes are ignored. Only the write-complete pulse acts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdSetWel | input | 1 | Set-enable-latch strobe |
| cmdClrWel | input | 1 | Clear-enable-latch strobe |
| cmdWrStatus | input | 1 | Status write strobe |
| wrStatusData | input | 8 | Data byte for status write |
| statShifting | input | 1 | High while a status data byte is being shifted in |
| cmdArrayWrite | input | 1 | Array write request strobe |
| arrayAddr | input | ADDR_W | Target address of array write |
| wpPinN | input | 1 | Active-low hardware protect pin |
| busy | input | 1 | Internal write cycle running |
| cycleDone | input | 1 | Write cycle completed pulse |
| statusByte | output | 8 | Status byte for readback |
| statusWrOk | output | 1 | Status write permitted pulse |
| arrayWrOk | output | 1 | Array write permitted pulse |

## Verification
A wrong protect level shows up as a wrong permit on the first array write into the affected quarter. It also shows in bits 3..2 of the status readback one cycle after the status write. A stuck or lost enable latch is visible in bit 1 in the cycle after the strobe, and it makes the next write request's permit pulse wrong. A stale abort flag or a wrong lock decision appears as a missing or extra status permit pulse on the very next status write. The sweep covers every protect level against every address quarter.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadStatus;
    logic grantArray;
    logic armAbort;
    logic clearAbort;
  } wpgStrobe_t;
endpackage

// File: rtl/wpg_ctrl.sv
module wpg_ctrl
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdSetWel,
  input  logic              cmdClrWel,
  input  logic              cmdWrStatus,
  input  logic              statShifting,
  input  logic              cmdArrayWrite,
  input  logic [ADDR_W-1:0] arrayAddr,
  input  logic              wpPinN,
  input  logic              busy,
  input  logic              cycleDone,
  input  logic              wpenQ,
  input  logic [1:0]        bpQ,
  input  logic              welQ,
  input  logic              abortQ,
  output wpgStrobe_t        strobe
);
  localparam int TOP_LSB = ADDR_W - 2;

  logic       idle;
  logic       hwLock;
  logic [1:0] topBits;
  logic       inRegion;

  assign idle    = ~busy;
  assign hwLock  = wpenQ & ~wpPinN;
  assign topBits = arrayAddr[TOP_LSB +: 2];

  always_comb begin
    unique case (bpQ)
      2'b00:   inRegion = 1'b0;
      2'b01:   inRegion = (topBits == 2'b11);
      2'b10:   inRegion = topBits[1];
      default: inRegion = 1'b1;
    endcase
  end

  always_comb begin
    strobe            = '0;
    strobe.setWel     = idle & cmdSetWel & ~cmdClrWel;
    strobe.clrWel     = (idle & cmdClrWel) | cycleDone;
    strobe.loadStatus = idle & cmdWrStatus & welQ & ~hwLock & ~abortQ;
    strobe.grantArray = idle & cmdArrayWrite & welQ & ~inRegion;
    strobe.armAbort   = statShifting & hwLock;
    strobe.clearAbort = cmdWrStatus;
  end

  // R8: whole-array level never grants an array write
  assert_all_protected_R8: assert property (@(posedge clk) disable iff (!rstN)
    (bpQ == 2'b11) |-> !strobe.grantArray);

  // R7: no status load while the lock condition holds
  assert_lock_blocks_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wpenQ && !wpPinN) |-> !strobe.loadStatus);
endmodule

// File: rtl/wpg_datapath.sv
module wpg_datapath
  import wpg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  wpgStrobe_t strobe,
  input  logic [7:0] wrStatusData,
  input  logic       busy,
  input  logic       cycleDone,
  output logic       wpenQ,
  output logic [1:0] bpQ,
  output logic       welQ,
  output logic       abortQ,
  output logic [7:0] statusByte,
  output logic       statusWrOk,
  output logic       arrayWrOk
);
  localparam int WPEN_BIT = 7;
  localparam int BP_LSB   = 2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wpenQ      <= 1'b0;
      bpQ        <= 2'b00;
      welQ       <= 1'b0;
      abortQ     <= 1'b0;
      statusWrOk <= 1'b0;
      arrayWrOk  <= 1'b0;
    end else begin
      if (strobe.clrWel)      welQ <= 1'b0;
      else if (strobe.setWel) welQ <= 1'b1;
      if (strobe.loadStatus) begin
        wpenQ <= wrStatusData[WPEN_BIT];
        bpQ   <= wrStatusData[BP_LSB +: 2];
      end
      if (strobe.clearAbort)    abortQ <= 1'b0;
      else if (strobe.armAbort) abortQ <= 1'b1;
      statusWrOk <= strobe.loadStatus;
      arrayWrOk  <= strobe.grantArray;
    end
  end

  assign statusByte = busy ? 8'hFF : {wpenQ, 3'b000, bpQ, welQ, 1'b0};

  // R9: an array permit only follows a cycle with the latch set
  assert_array_needs_wel_R9: assert property (@(posedge clk) disable iff (!rstN)
    arrayWrOk |-> $past(welQ));

  // R5: write completion leaves the latch clear
  assert_done_clears_wel_R5: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !welQ);

  // R11: while busy without completion, latch and protect bits hold
  assert_busy_freeze_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !cycleDone) |=> ($stable(welQ) && $stable(bpQ) && $stable(wpenQ)));
endmodule

// File: rtl/wp_status_guard.sv
module wp_status_guard
  import wpg_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdSetWel,
  input  logic              cmdClrWel,
  input  logic              cmdWrStatus,
  input  logic [7:0]        wrStatusData,
  input  logic              statShifting,
  input  logic              cmdArrayWrite,
  input  logic [ADDR_W-1:0] arrayAddr,
  input  logic              wpPinN,
  input  logic              busy,
  input  logic              cycleDone,
  output logic [7:0]        statusByte,
  output logic              statusWrOk,
  output logic              arrayWrOk
);
  wpgStrobe_t strobe;
  logic       wpenQ;
  logic [1:0] bpQ;
  logic       welQ;
  logic       abortQ;

  wpg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .cmdSetWel(cmdSetWel), .cmdClrWel(cmdClrWel), .cmdWrStatus(cmdWrStatus),
    .statShifting(statShifting), .cmdArrayWrite(cmdArrayWrite),
    .arrayAddr(arrayAddr), .wpPinN(wpPinN), .busy(busy), .cycleDone(cycleDone),
    .wpenQ(wpenQ), .bpQ(bpQ), .welQ(welQ), .abortQ(abortQ), .strobe(strobe)
  );

  wpg_datapath dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrStatusData(wrStatusData),
    .busy(busy), .cycleDone(cycleDone),
    .wpenQ(wpenQ), .bpQ(bpQ), .welQ(welQ), .abortQ(abortQ),
    .statusByte(statusByte), .statusWrOk(statusWrOk), .arrayWrOk(arrayWrOk)
  );
endmodule

// File: tb/wp_status_guard_tb.sv
module wp_status_guard_tb_top;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdSetWel = 0, cmdClrWel = 0, cmdWrStatus = 0, statShifting = 0;
  logic          cmdArrayWrite = 0, wpPinN = 1, busy = 0, cycleDone = 0;
  logic [7:0]    wrStatusData = 0;
  logic [AW-1:0] arrayAddr = 0;
  logic [7:0]    statusByte;
  logic          statusWrOk, arrayWrOk;

  int vecCount = 0;
  int failCount = 0;

  logic       mWpen = 0, mWel = 0, mAbort = 0;
  logic [1:0] mBp = 0;

  always #4 clk = ~clk;

  wp_status_guard #(.ADDR_W(AW)) dut_i (.*);

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; model update follows the requirements
  task automatic cyc(input logic sw, input logic cw, input logic ws, input logic [7:0] d,
                     input logic sh, input logic aw, input logic [AW-1:0] ad,
                     input logic pin, input logic bz, input logic dn, input string req);
    logic lock, prot, expS, expA;
    int t, span;
    cmdSetWel = sw; cmdClrWel = cw; cmdWrStatus = ws; wrStatusData = d;
    statShifting = sh; cmdArrayWrite = aw; arrayAddr = ad;
    wpPinN = pin; busy = bz; cycleDone = dn;
    lock = mWpen && !pin;
    t    = int'(ad[AW-1 -: 2]);
    span = (mBp == 0) ? 0 : (1 << (int'(mBp) - 1));
    prot = (t >= 4 - span);
    expS = !bz && ws && mWel && !lock && !mAbort;
    expA = !bz && aw && mWel && !prot;
    if (expS) begin mWpen = d[7]; mBp = d[3:2]; end
    if (dn || (!bz && cw)) mWel = 0;
    else if (!bz && sw) mWel = 1;
    if (ws) mAbort = 0;
    else if (sh && lock) mAbort = 1;
    @(posedge clk);
    @(negedge clk);
    chk({7'b0, statusWrOk}, {7'b0, expS}, {req, " status permit"});
    chk({7'b0, arrayWrOk}, {7'b0, expA}, {req, " array permit"});
    chk(statusByte, bz ? 8'hFF : {mWpen, 3'b000, mBp, mWel, 1'b0}, {req, " status byte"});
    cmdSetWel = 0; cmdClrWel = 0; cmdWrStatus = 0; statShifting = 0;
    cmdArrayWrite = 0; cycleDone = 0;
  endtask

  initial begin
    #(8 * 200000);
    failCount++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(statusByte, 8'h00, "R1 reset status byte");
    // R6 status write without latch is refused
    cyc(0,0,1,8'h8C,0,0,'0,1,0,0,"R6 no latch");
    // R4 set, clear with pin low, clear wins
    cyc(1,0,0,8'h00,0,0,'0,1,0,0,"R4 set latch");
    cyc(0,1,0,8'h00,0,0,'0,0,0,0,"R4 clear pin low");
    cyc(1,1,0,8'h00,0,0,'0,1,0,0,"R4 clear wins");
    // R9 array write without latch
    cyc(0,0,0,8'h00,0,1,16'h0123,1,0,0,"R9 no latch");
    // R8 R6 R2 sweep of every level against every quarter
    for (int bp = 0; bp < 4; bp++) begin
      cyc(1,0,0,8'h00,0,0,'0,1,0,0,"R4 set latch");
      cyc(0,0,1,{1'b0,3'b111,2'(bp),2'b11},0,0,'0,1,0,0,"R6 R2 load level");
      for (int q = 0; q < 4; q++)
        for (int lo = 0; lo < 3; lo++)
          cyc(0,0,0,8'h00,0,1,{2'(q), 14'(lo * 14'h1FFF)},1,0,0,"R8 R9 region");
    end
    // R3 R11 busy: reads FF, strobes ignored
    cyc(0,1,0,8'h00,0,0,'0,1,1,0,"R11 clear while busy");
    cyc(0,0,1,8'h00,0,0,'0,1,1,0,"R3 R11 status write while busy");
    cyc(0,0,0,8'h00,0,1,'0,1,1,0,"R11 array write while busy");
    // R5 completion clears latch
    cyc(0,0,0,8'h00,0,0,'0,1,1,1,"R5 done");
    cyc(0,0,0,8'h00,0,0,'0,1,0,0,"R5 after done");
    // R7 pin lock
    cyc(1,0,0,8'h00,0,0,'0,1,0,0,"R4 set");
    cyc(0,0,1,8'h80,0,0,'0,1,0,0,"R7 set sticky bit");
    cyc(0,0,1,8'h8C,0,0,'0,0,0,0,"R7 locked write");
    // R10 abort when lock seen mid-shift
    cyc(0,0,0,8'h00,1,0,'0,0,0,0,"R10 shift pin low");
    cyc(0,0,0,8'h00,1,0,'0,1,0,0,"R10 shift pin high");
    cyc(0,0,1,8'h84,0,0,'0,1,0,0,"R10 aborted write");
    cyc(0,0,0,8'h00,1,0,'0,1,0,0,"R10 clean shift");
    cyc(0,0,1,8'h84,0,0,'0,1,0,0,"R10 clean write");
    cyc(0,0,1,8'h00,0,0,'0,1,0,0,"R7 clear sticky bit");
    // R7 pin ignored when sticky bit is 0
    cyc(0,0,0,8'h00,1,0,'0,0,0,0,"R7 shift pin low unlocked");
    cyc(0,0,1,8'h08,0,0,'0,0,0,0,"R7 pin no effect");
    cyc(0,0,0,8'h00,0,1,16'hFFFF,1,0,0,"R8 top half");
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end
endmodule